// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs from one input clock. Each channel first slows the clock by a programmable divider (divide by prescale plus one). It then counts the slowed ticks over a programmable number of ticks per period. The output is high for a programmable number of those ticks at the start of every period. Software sets the block up through a single-cycle synchronous register port. The port has a byte address, a write strobe, write data and combinational read data.

Every channel owns a group of three registers: control, duty and period. Channel n's group starts at byte address n×0x10. One chip-wide enable register sits at 0x3C. A channel runs only while both its own enable and the chip-wide enable are set. New duty, period and prescale values are taken up only at a period boundary, so a running waveform never shows a cut-short cycle.

Top module: `pwm_quad`

## Requirements
- R1: Channel n (0..3) has its control word at byte address n×0x10+0x0, its duty word at +0x4 and its period word at +0x8. Control bit 0 is the channel enable and bits 15:2 hold the 14-bit prescale. Control bit 1 and bits 31:16 read 0. Duty and period keep bits 15:0, and their bits 31:16 read 0. Each register reads back what was last written to its kept bits.
- R2: The chip-wide enable is bit 0 of the word at 0x3C. It reads back as written, with all other bits 0.
- R3: Any other address, including unaligned ones, reads 0. A write to such an address changes no register.
- R4: While either the chip-wide enable or the channel enable is 0, the output of that channel is 0 and its counters are held at zero.
- R5: While running, a channel's output period is (prescale+1)×period input cycles. Its high time at the start of each period is (prescale+1)×duty input cycles.
- R6: If duty is greater than or equal to period, the output stays high without a gap.
- R7: A period value of 0 keeps the output low even when the channel is enabled.
- R8: A write to duty, period or prescale during a period does not change that period. The new value applies from the next period.
- R9: After the write that enables a channel (with the other enable already set), the output stays low for one cycle. The output then goes high on the next clock edge, which starts the first period.
- R10: Channels run independently, and each follows only its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A register write lands on the clock edge where bus_we is high. Read data follows the address in the same cycle. Readback checks therefore sample bus_rdata shortly after the address is driven, at a falling edge that follows the write.

The bench drives every input at a falling edge and samples every output at a falling edge. An enable write that lands on edge E leaves the output low at the next falling edge and high one edge later. Clearing an enable forces the output low before the next falling edge. The bench measures waveforms by counting falling-edge samples from a rising output to the next one. Each sample equals one input clock cycle, so high time and period are compared directly against (prescale+1)×duty and (prescale+1)×period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH = 4;
  localparam int PSC_W  = 14;
  localparam int CNT_W  = 16;
  localparam int CH_SEL_W = $clog2(NUM_CH);

  typedef struct packed {
    logic             en;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] per;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ch_cfg_t           cfg [NUM_CH],
  output logic              master_en
);
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(8'h3C);
  localparam int PSC_LSB = 2;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:CNT_W], wdata[1]};

  logic master_q, master_d;
  ch_cfg_t cfg_q [NUM_CH];
  ch_cfg_t cfg_d [NUM_CH];

  always_comb begin
    master_d = master_q;
    if (we && addr == MASTER_ADDR) master_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_q <= 1'b0;
    else        master_q <= master_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * 16);
    always_comb begin
      cfg_d[c] = cfg_q[c];
      if (we) begin
        if (addr == BASE) begin
          cfg_d[c].en  = wdata[0];
          cfg_d[c].psc = wdata[PSC_LSB +: PSC_W];
        end
        if (addr == BASE + ADDR_W'(4)) cfg_d[c].duty = wdata[CNT_W-1:0];
        if (addr == BASE + ADDR_W'(8)) cfg_d[c].per  = wdata[CNT_W-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[c] <= '0;
      else        cfg_q[c] <= cfg_d[c];
    end
    assign cfg[c] = cfg_q[c];
  end

  always_comb begin
    rdata = '0;
    if (addr == MASTER_ADDR) rdata[0] = master_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c * 16)) begin
        rdata[0] = cfg_q[c].en;
        rdata[PSC_LSB +: PSC_W] = cfg_q[c].psc;
      end
      if (addr == ADDR_W'(c * 16 + 4)) rdata[CNT_W-1:0] = cfg_q[c].duty;
      if (addr == ADDR_W'(c * 16 + 8)) rdata[CNT_W-1:0] = cfg_q[c].per;
    end
  end

  assign master_en = master_q;

  p_master_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == MASTER_ADDR) |=> (master_en == $past(wdata[0])));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    master_en,
  input  ch_cfg_t cfg,
  output logic    pwm_o
);
  logic             enabled;
  logic             run_q, run_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  logic [PSC_W-1:0] sh_psc_q, sh_psc_d;
  logic [CNT_W-1:0] sh_duty_q, sh_duty_d;
  logic [CNT_W-1:0] sh_per_q, sh_per_d;
  logic             psc_end, per_end;

  assign enabled = master_en & cfg.en;
  assign psc_end = (psc_q == sh_psc_q);
  assign per_end = psc_end && (tick_q == sh_per_q - CNT_W'(1));

  always_comb begin
    run_d     = run_q;
    psc_d     = psc_q;
    tick_d    = tick_q;
    sh_psc_d  = sh_psc_q;
    sh_duty_d = sh_duty_q;
    sh_per_d  = sh_per_q;
    if (!enabled) begin
      run_d  = 1'b0;
      psc_d  = '0;
      tick_d = '0;
    end else if (!run_q || per_end) begin
      run_d     = (cfg.per != '0);
      psc_d     = '0;
      tick_d    = '0;
      sh_psc_d  = cfg.psc;
      sh_duty_d = cfg.duty;
      sh_per_d  = cfg.per;
    end else if (psc_end) begin
      psc_d  = '0;
      tick_d = tick_q + CNT_W'(1);
    end else begin
      psc_d = psc_q + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      psc_q     <= '0;
      tick_q    <= '0;
      sh_psc_q  <= '0;
      sh_duty_q <= '0;
      sh_per_q  <= '0;
    end else begin
      run_q     <= run_d;
      psc_q     <= psc_d;
      tick_q    <= tick_d;
      sh_psc_q  <= sh_psc_d;
      sh_duty_q <= sh_duty_d;
      sh_per_q  <= sh_per_d;
    end
  end

  assign pwm_o = enabled & run_q & (tick_q < sh_duty_q);

  p_off_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> (psc_q == '0 && tick_q == '0 && !run_q));
  p_psc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (psc_q <= sh_psc_q));
  p_tick_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sh_per_q != '0 && tick_q < sh_per_q));
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && run_q && !per_end) |=>
      ($stable(sh_duty_q) && $stable(sh_per_q) && $stable(sh_psc_q)));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  ch_cfg_t cfg [NUM_CH];
  logic    master_en;

  pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .cfg       (cfg),
    .master_en (master_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_chan i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .cfg       (cfg[c]),
      .pwm_o     (pwm_out[c])
    );
  end

  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pwm_out == '0));
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_quad i_pwm_quad (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cfg_ch(input int ch, input int psc, input int duty, input int per, input bit en);
    wr(6'(ch * 16 + 4), 32'(duty));
    wr(6'(ch * 16 + 8), 32'(per));
    wr(6'(ch * 16), (32'(psc) << 2) | 32'(en));
  endtask

  // waits for a rising output, then counts high samples and full period
  task automatic measure(input int ch, output int hi, output int per);
    logic prev;
    int guard;
    hi = 0; per = 0; guard = 0;
    @(negedge clk); prev = pwm_out[ch];
    while (!(pwm_out[ch] && !prev) && guard < 3000) begin
      prev = pwm_out[ch]; @(negedge clk); guard++;
    end
    while (pwm_out[ch] && guard < 3000) begin
      hi++; per++; @(negedge clk); guard++;
    end
    while (!pwm_out[ch] && guard < 3000) begin
      per++; @(negedge clk); guard++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R4 reset outputs", 32'(pwm_out), 32'h0);
    rd(6'h00, d); chk("R1 reset ctrl", d, 32'h0);
    rd(6'h3C, d); chk("R2 reset master", d, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(6'h20, 32'hFFFF_FFFE); rd(6'h20, d); chk("R1 ctrl fields", d, 32'h0000_FFFC);
    wr(6'h24, 32'hABCD_1234); rd(6'h24, d); chk("R1 duty", d, 32'h0000_1234);
    wr(6'h28, 32'h5555_8001); rd(6'h28, d); chk("R1 period", d, 32'h0000_8001);
    wr(6'h30, 32'h0000_0006); rd(6'h30, d); chk("R1 ctrl ch3", d, 32'h0000_0004);
    wr(6'h3C, 32'hFFFF_FFFE); rd(6'h3C, d); chk("R2 master clear", d, 32'h0);
    wr(6'h20, 32'h0); wr(6'h24, 32'h0); wr(6'h28, 32'h0); wr(6'h30, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(6'h10, 32'h0000_0028);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, d); chk("R3 read 0x0C", d, 32'h0);
    wr(6'h11, 32'hFFFF_FFFF); rd(6'h11, d); chk("R3 read 0x11", d, 32'h0);
    rd(6'h10, d); chk("R3 ctrl untouched", d, 32'h0000_0028);
    wr(6'h2C, 32'h1234); rd(6'h2C, d); chk("R3 read 0x2C", d, 32'h0);
    wr(6'h10, 32'h0);
  endtask

  task automatic t_gating;
    int hi, per, seen;
    cfg_ch(3, 0, 2, 4, 1'b1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out[3]) seen++; end
    chk("R4 master off keeps low", 32'(seen), 32'h0);
    wr(6'h3C, 32'h1);
    measure(3, hi, per);
    chk("R5 ch3 high", 32'(hi), 32'd2);
    chk("R5 ch3 period", 32'(per), 32'd4);
    wr(6'h3C, 32'h0);
    chk("R4 master clear forces low", 32'(pwm_out[3]), 32'h0);
    wr(6'h3C, 32'h1);
    wr(6'h30, 32'h0);
    chk("R4 channel clear forces low", 32'(pwm_out[3]), 32'h0);
  endtask

  task automatic t_basic;
    int hi, per;
    cfg_ch(0, 0, 2, 5, 1'b1);
    cfg_ch(1, 3, 1, 4, 1'b1);
    measure(0, hi, per);
    chk("R5 ch0 high", 32'(hi), 32'd2);
    chk("R5 ch0 period", 32'(per), 32'd5);
    measure(1, hi, per);
    chk("R10 ch1 high prescaled", 32'(hi), 32'd4);
    chk("R10 ch1 period prescaled", 32'(per), 32'd16);
    measure(0, hi, per);
    chk("R10 ch0 unaffected", 32'(per), 32'd5);
    wr(6'h00, 32'h0); wr(6'h10, 32'h0);
  endtask

  task automatic t_full_duty;
    int lows;
    cfg_ch(2, 1, 7, 5, 1'b1);
    @(negedge clk); @(negedge clk);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!pwm_out[2]) lows++; end
    chk("R6 duty over period stays high", 32'(lows), 32'h0);
    wr(6'h20, 32'h0);
  endtask

  task automatic t_zero_period;
    int seen;
    cfg_ch(2, 0, 3, 0, 1'b1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out[2]) seen++; end
    chk("R7 zero period low", 32'(seen), 32'h0);
    wr(6'h20, 32'h0);
  endtask

  task automatic t_boundary;
    logic prev;
    int hi, per, guard;
    cfg_ch(0, 0, 8, 10, 1'b1);
    guard = 0;
    @(negedge clk); prev = pwm_out[0];
    while (!(pwm_out[0] && !prev) && guard < 100) begin
      prev = pwm_out[0]; @(negedge clk); guard++;
    end
    bus_addr = 6'h04; bus_wdata = 32'd2; bus_we = 1'b1;
    hi = 0;
    while (pwm_out[0] && guard < 200) begin
      hi++; @(negedge clk); bus_we = 1'b0; guard++;
    end
    bus_we = 1'b0;
    chk("R8 running period keeps old duty", 32'(hi), 32'd8);
    measure(0, hi, per);
    chk("R8 next period new duty", 32'(hi), 32'd2);
    chk("R8 period unchanged", 32'(per), 32'd10);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_restart;
    cfg_ch(1, 2, 1, 2, 1'b0);
    wr(6'h10, 32'h0000_0009);
    chk("R9 low right after enable", 32'(pwm_out[1]), 32'h0);
    @(negedge clk);
    chk("R9 high one edge later", 32'(pwm_out[1]), 32'h1);
    wr(6'h10, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_unmapped();
    t_gating();
    t_basic();
    t_full_duty();
    t_zero_period();
    t_boundary();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule